// File: doc/BRIEF.md
# 10 Mbps Receive Framer

This block sits between the bit-serial output of a 10 Mbps receive front end and a nibble-wide receive interface of the MII kind. The front end supplies one recovered data bit per clock, a carrier-present level and a one-cycle end-of-frame pulse. The framer raises carrier sense, finds the start-of-frame delimiter and packs the serial stream into nibbles. It presents each nibble on `rxd` with a receive-data-valid flag and a one-cycle strobe that marks where the MII receive clock would sample.

A mode input, latched when each frame begins, selects between two kinds of output. In strip mode, data-valid stays low through the preamble and opens on the delimiter pair 5, D, so the first nibbles after it belong to the destination address. In pass mode, data-valid rises with carrier sense and a synthesized preamble nibble 5 is presented from the start. If the preamble emitted so far ends halfway through an octet, one padding nibble 5 is inserted so that the delimiter and the data fall on octet boundaries. Leading preamble bits lost by the front end only shorten the output preamble.

After the delimiter, queued nibbles keep flowing at one per four clocks. On the end-of-frame pulse, the queue drains and then both sense signals drop. If carrier disappears without an end-of-frame pulse, the frame is abandoned at once.

Top module: `rx10_framer`

## Requirements
- R1: In idle, when `carrier` is sampled high, `crs` is high from the next clock in either mode.
- R2: In strip mode, `rx_dv` is low and `rxd` is 0 throughout the preamble. `rx_dv` then rises with `rxd` = 5, the next strobed nibble is D (4'hD), and the data nibbles follow.
- R3: In pass mode, `rx_dv` rises on the same clock as `crs` with `rxd` = 5, and every strobed nibble before the delimiter is 5.
- R4: Byte alignment is set by the first two consecutive 1 bits after carrier start. Data nibble k carries bits 4k to 4k+3 counted from the bit that follows that pair, with the earliest bit in `rxd[0]`.
- R5: In pass mode, the number of 5 nibbles presented before D is odd, so preamble and delimiter form whole octets. A padding 5 is inserted when it is needed.
- R6: After an end-of-frame pulse, every complete data nibble is still presented. `crs` and `rx_dv` then fall on the same clock with `rxd` = 0. Fewer than four trailing bits are dropped, and `carrier` is ignored while the queue drains.
- R7: If `carrier` drops during preamble or data without an end-of-frame pulse, `crs`, `rx_dv` and `rxd` are all zero on the next clock.
- R8: `rxd` is 0 whenever `rx_dv` is low.
- R9: `rxd_stb` is a one-cycle pulse in the cycle each new nibble first appears on `rxd`, and two strobes are never fewer than four clocks apart.
- R10: The mode is taken from `strip_pre` when the frame starts. Changing `strip_pre` during the frame has no effect on its output.
- R11: An end-of-frame pulse before any delimiter returns the block to idle, with `crs`, `rx_dv` and `rxd` zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_pre | input | 1 | 1 = strip preamble, 0 = pass preamble |
| carrier | input | 1 | Carrier present from the front end |
| rx_bit | input | 1 | Recovered serial data bit |
| eof | input | 1 | One-cycle end-of-frame marker |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Receive nibble |
| rxd_stb | output | 1 | High in the cycle a new nibble appears on rxd |

## Verification
The assertions assume that the front end changes `carrier`, `rx_bit` and `eof` only in step with the clock. They also assume that `eof` is a single-cycle pulse raised only while `carrier` is high, and that `carrier` falls within a few clocks of it so that a drained frame does not restart. The bench drives every input on the falling edge. It raises `eof` for exactly one cycle with `carrier` still high and clears `carrier` on the next cycle. It separates frames by enough idle clocks for the queue to drain before the next carrier arrives.

// File: rtl/rx10_framer.sv
module rx10_framer #(
  parameter int QDEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strip_pre,
  input  logic       carrier,
  input  logic       rx_bit,
  input  logic       eof,
  output logic       crs,
  output logic       rx_dv,
  output logic [3:0] rxd,
  output logic       rxd_stb
);

  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_DRAIN} state_t;

  state_t          st;
  logic [1:0]      ph;
  logic            prev;
  logic [2:0]      sh;
  logic            mode_q;
  logic            pre_odd;
  logic [3:0]      q   [QDEPTH];
  logic [3:0]      q_n [QDEPTH];
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_n;

  logic       slot, sfd_hit, push_en, pad;
  logic [3:0] nib_in;

  assign slot    = (ph == 2'd3);
  assign sfd_hit = carrier && !eof && prev && rx_bit;
  assign push_en = (st == S_DATA) && !eof;
  assign nib_in  = {rx_bit, sh};
  assign pad     = !mode_q && pre_odd;

  always_comb begin
    for (int i = 0; i < QDEPTH - 1; i++) q_n[i] = q[i+1];
    q_n[QDEPTH-1] = 4'd0;
    cnt_n = cnt - CW'(1);
    if (push_en) begin
      for (int i = 0; i < QDEPTH; i++)
        if (CW'(i) == cnt_n) q_n[i] = nib_in;
      cnt_n = cnt_n + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 2'd0;
      prev    <= 1'b0;
      sh      <= 3'd0;
      mode_q  <= 1'b0;
      pre_odd <= 1'b0;
      cnt     <= '0;
      crs     <= 1'b0;
      rx_dv   <= 1'b0;
      rxd     <= 4'd0;
      rxd_stb <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= 4'd0;
    end else begin
      rxd_stb <= 1'b0;
      case (st)
        S_IDLE: begin
          ph <= 2'd0;
          if (carrier && !eof) begin
            st      <= S_PRE;
            mode_q  <= strip_pre;
            crs     <= 1'b1;
            prev    <= rx_bit;
            cnt     <= '0;
            pre_odd <= !strip_pre;
            if (!strip_pre) begin
              rx_dv   <= 1'b1;
              rxd     <= PRE_NIB;
              rxd_stb <= 1'b1;
            end
          end
        end

        S_PRE: begin
          if (!carrier || eof) begin
            st    <= S_IDLE;
            crs   <= 1'b0;
            rx_dv <= 1'b0;
            rxd   <= 4'd0;
            ph    <= 2'd0;
          end else if (sfd_hit) begin
            st <= S_DATA;
            ph <= 2'd0;
            for (int i = 0; i < QDEPTH; i++) q[i] <= 4'd0;
            q[0] <= PRE_NIB;
            q[1] <= pad ? PRE_NIB : SFD_NIB;
            q[2] <= pad ? SFD_NIB : 4'd0;
            cnt  <= pad ? CW'(3) : CW'(2);
          end else begin
            prev <= rx_bit;
            ph   <= ph + 2'd1;
            if (slot && !mode_q) begin
              rxd     <= PRE_NIB;
              rxd_stb <= 1'b1;
              pre_odd <= !pre_odd;
            end
          end
        end

        S_DATA: begin
          if (!carrier) begin
            st    <= S_IDLE;
            crs   <= 1'b0;
            rx_dv <= 1'b0;
            rxd   <= 4'd0;
            ph    <= 2'd0;
            cnt   <= '0;
          end else begin
            ph <= ph + 2'd1;
            if (!eof) sh <= {rx_bit, sh[2:1]};
            if (slot) begin
              for (int i = 0; i < QDEPTH; i++) q[i] <= q_n[i];
              cnt     <= cnt_n;
              rxd     <= q[0];
              rx_dv   <= 1'b1;
              rxd_stb <= 1'b1;
            end
            if (eof) st <= S_DRAIN;
          end
        end

        default: begin
          ph <= ph + 2'd1;
          if (slot) begin
            if (cnt != '0) begin
              for (int i = 0; i < QDEPTH; i++) q[i] <= q_n[i];
              cnt     <= cnt_n;
              rxd     <= q[0];
              rxd_stb <= 1'b1;
            end else begin
              st    <= S_IDLE;
              crs   <= 1'b0;
              rx_dv <= 1'b0;
              rxd   <= 4'd0;
              ph    <= 2'd0;
            end
          end
        end
      endcase
    end
  end

  p_dv_within_crs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  p_rxd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rxd == 4'd0));

  p_crs_opens_dv_by_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> (rx_dv == !mode_q));

  p_strip_opens_on_5_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) && $past(crs) |-> (rxd == PRE_NIB));

  p_carrier_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PRE) || (st == S_DATA)) && !carrier |=> !crs && !rx_dv && (rxd == 4'd0));

  p_eof_in_preamble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) && eof |=> !crs && !rx_dv);

  p_crs_falls_with_dv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> !rx_dv);

  p_dv_falls_with_crs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dv) |-> !crs);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(3));

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_stb |=> !rxd_stb);

  p_rxd_moves_on_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv && $past(rx_dv) && !$stable(rxd) |-> rxd_stb);

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crs && $past(crs) |-> $stable(mode_q));

endmodule

// File: tb/test_rx10_framer.sv
`timescale 1ns/1ps
module test_rx10_framer;
  logic clk = 1'b0;
  logic rst_n, strip_pre, carrier, rx_bit, eof;
  logic crs, rx_dv, rxd_stb;
  logic [3:0] rxd;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ngot = 0;
  int last_stb = -1;
  int stb_bad = 0;
  int quiet_bad = 0;
  logic [3:0] got [64];
  logic [3:0] tx  [32];
  int ntx = 0;

  always #2.5 clk = ~clk;

  rx10_framer i_rx10_framer (
    .clk(clk), .rst_n(rst_n), .strip_pre(strip_pre), .carrier(carrier),
    .rx_bit(rx_bit), .eof(eof), .crs(crs), .rx_dv(rx_dv), .rxd(rxd),
    .rxd_stb(rxd_stb)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rx_dv && rxd != 4'd0) quiet_bad++;
    if (rxd_stb) begin
      if (last_stb >= 0 && (cyc - last_stb) < 4) stb_bad++;
      last_stb = cyc;
      if (rx_dv) begin
        if (ngot < 64) got[ngot] = rxd;
        ngot++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    rx_bit  = b;
    carrier = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_mon();
    ngot = 0; last_stb = -1; stb_bad = 0; quiet_bad = 0;
  endtask

  task automatic send_preamble(input bit mode, input int npairs, input bit flip);
    strip_pre = mode;
    put_bit(1'b1);
    chk(crs == 1'b1, "R1 crs after carrier", crs, 1);
    if (mode) chk(!rx_dv && rxd == 4'd0, "R2 strip quiet at start", rx_dv, 0);
    else      chk(rx_dv && rxd == 4'h5, "R3 pass opens with 5", rxd, 5);
    if (flip) strip_pre = !mode;
    put_bit(1'b0);
    for (int i = 1; i < npairs; i++) begin put_bit(1'b1); put_bit(1'b0); end
    if (flip) chk(rx_dv == !mode, "R10 mode change ignored", rx_dv, !mode);
    if (mode) chk(!rx_dv, "R2 dv low in preamble", rx_dv, 0);
    put_bit(1'b1); put_bit(1'b1);
  endtask

  task automatic send_data(input int extra);
    for (int k = 0; k < ntx; k++)
      for (int b = 0; b < 4; b++) put_bit(tx[k][b]);
    for (int e = 0; e < extra; e++) put_bit(1'b1);
  endtask

  task automatic end_frame();
    eof = 1'b1; carrier = 1'b1;
    @(negedge clk);
    eof = 1'b0; carrier = 1'b0; rx_bit = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic verify_output(input bit mode);
    int lead;
    if (mode) begin
      chk(ngot == ntx + 2, "R6 strip nibble count", ngot, ntx + 2);
      chk(got[0] == 4'h5, "R2 first nibble", got[0], 5);
      chk(got[1] == 4'hD, "R2 delimiter nibble", got[1], 13);
      lead = 1;
    end else begin
      lead = ngot - ntx - 1;
      chk(lead >= 3 && lead % 2 == 1, "R5 odd preamble nibble count", lead, 3);
      for (int i = 0; i < lead && i < 64; i++)
        chk(got[i] == 4'h5, "R3 preamble nibble", got[i], 5);
      if (lead >= 0 && lead < 64) chk(got[lead] == 4'hD, "R5 delimiter after padding", got[lead], 13);
    end
    for (int k = 0; k < ntx; k++)
      if (lead + 1 + k < 64)
        chk(got[lead + 1 + k] == tx[k], "R4 data nibble", got[lead + 1 + k], tx[k]);
    chk(!crs && !rx_dv && rxd == 4'd0, "R6 closed after drain", {crs, rx_dv}, 0);
    chk(stb_bad == 0, "R9 strobe spacing", stb_bad, 0);
    chk(quiet_bad == 0, "R8 rxd zero without dv", quiet_bad, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; strip_pre = 1'b1; carrier = 1'b0; rx_bit = 1'b0; eof = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!crs && !rx_dv && rxd == 4'd0 && !rxd_stb, "R8 reset state", {crs, rx_dv, rxd_stb}, 0);
  endtask

  task automatic t_strip_frame(input int npairs, input int extra);
    clear_mon();
    send_preamble(1'b1, npairs, 1'b0);
    send_data(extra);
    end_frame();
    verify_output(1'b1);
  endtask

  task automatic t_pass_frame(input int npairs, input int extra);
    clear_mon();
    send_preamble(1'b0, npairs, 1'b0);
    send_data(extra);
    end_frame();
    verify_output(1'b0);
  endtask

  task automatic t_mode_flip(input bit mode);
    clear_mon();
    send_preamble(mode, 4, 1'b1);
    send_data(0);
    end_frame();
    verify_output(mode);
    strip_pre = mode;
  endtask

  task automatic t_abort_data();
    clear_mon();
    send_preamble(1'b1, 3, 1'b0);
    for (int b = 0; b < 8; b++) put_bit(b[0]);
    chk(rx_dv == 1'b1, "R7 data flowing before loss", rx_dv, 1);
    carrier = 1'b0; rx_bit = 1'b0;
    @(negedge clk);
    chk(!crs && !rx_dv && rxd == 4'd0, "R7 carrier loss in data", {crs, rx_dv, rxd}, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_abort_pre();
    clear_mon();
    strip_pre = 1'b0;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    carrier = 1'b0;
    @(negedge clk);
    chk(!crs && !rx_dv && rxd == 4'd0, "R7 carrier loss in preamble", {crs, rx_dv, rxd}, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_eof_pre();
    clear_mon();
    strip_pre = 1'b0;
    for (int i = 0; i < 3; i++) begin put_bit(1'b1); put_bit(1'b0); end
    eof = 1'b1;
    @(negedge clk);
    chk(!crs && !rx_dv && rxd == 4'd0, "R11 eof in preamble", {crs, rx_dv, rxd}, 0);
    eof = 1'b0; carrier = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    t_reset();
    ntx = 8;
    tx[0] = 4'h1; tx[1] = 4'h2; tx[2] = 4'h4; tx[3] = 4'h8;
    tx[4] = 4'hF; tx[5] = 4'h0; tx[6] = 4'hD; tx[7] = 4'h3;
    t_strip_frame(4, 0);
    t_strip_frame(7, 2);
    t_pass_frame(3, 0);
    t_pass_frame(4, 1);
    t_pass_frame(6, 3);
    ntx = 5;
    tx[0] = 4'hA; tx[1] = 4'h5; tx[2] = 4'hC; tx[3] = 4'h7; tx[4] = 4'hE;
    t_pass_frame(5, 0);
    t_strip_frame(2, 3);
    t_mode_flip(1'b1);
    t_mode_flip(1'b0);
    t_abort_data();
    t_abort_pre();
    t_eof_pre();
    t_strip_frame(4, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule